// File: doc/BRIEF.md
# Segment Access Checker

This block turns a 32-bit offset into a linear address using the fields of a segment descriptor that is already loaded, and it checks whether the access is allowed. The descriptor supplies four things:

- a 32-bit base;
- a 20-bit limit;
- a granularity bit, which picks byte units or 4 KB units for the limit;
- a 2-bit descriptor privilege level and a code/data type bit.

Each request also carries the current privilege level and an access kind: fetch, read or write.

The check takes one registered cycle. In that cycle the block adds base and offset, compares the offset with the effective limit, and applies the privilege and type rules. One cycle after a request it presents the linear address, a result strobe, a combined "address usable" flag and three separate fault flags. A request can raise any number of the fault flags at once. The block reads no descriptor tables and does no paging.

Top module: `seg_access_top`

## Requirements
- R1: One cycle after a request, `lin_addr` equals `seg_base + offset` modulo 2^32, whatever the faults.
- R2: `res_valid` rises exactly one cycle after a request is presented. After reset, and in any cycle that follows a cycle with no request, `res_valid`, `lin_ok` and all fault flags are 0.
- R3: With `seg_gran` = 0 the limit counts bytes. An offset greater than `seg_limit` sets `flt_limit`. An offset equal to or below the limit does not.
- R4: With `seg_gran` = 1 the effective limit is `{seg_limit, 12'hFFF}`. An offset above it sets `flt_limit`. An offset equal to it does not.
- R5: For reads and writes, `flt_priv` is set when `cur_pl` is numerically greater than `seg_dpl`. Level 0 is the most privileged.
- R6: Fetches are never checked for privilege, so a fetch never sets `flt_priv`.
- R7: `flt_type` is set for a write to a code segment (`seg_is_code` = 1) and for a fetch from a data segment (`seg_is_code` = 0). A read never sets it, whatever the type.
- R8: `lin_ok` is 1 exactly when `res_valid` is 1 and none of the three fault flags is set.
- R9: The access kind is encoded in `acc_kind` as follows: 0 = fetch, 1 = read, 2 = write. Code 3 is handled exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 20 | Segment limit field |
| seg_gran | input | 1 | Limit unit: 0 = bytes, 1 = 4 KB |
| seg_dpl | input | 2 | Descriptor privilege level |
| seg_is_code | input | 1 | 1 = code segment, 0 = data segment |
| offset | input | 32 | Offset within the segment |
| cur_pl | input | 2 | Current privilege level |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| lin_addr | output | 32 | Linear address |
| lin_ok | output | 1 | Result valid with no fault |
| flt_limit | output | 1 | Offset is beyond the effective limit |
| flt_priv | output | 1 | Privilege level is insufficient |
| flt_type | output | 1 | Access kind is not allowed for the segment type |

## Verification
The bench sweeps every pairing of current and descriptor privilege, every access-kind code, both segment types and both granularities. For each combination it places the offset one below, exactly at and one above the effective limit, including limits of zero and the all-ones limit whose page-scaled bound wraps. The comparison point needs care. A `>=` comparison where `>` belongs fails exactly at the limit. A design that forgets the 12 low ones under page granularity rejects offsets inside the last page. Privilege and type mistakes show up as wrong flags in specific cells of the sweep: comparing in the wrong direction, checking fetches for privilege, or treating code 3 as a write. Bases near the top of the address space exercise the modulo wrap of the address adder.

// File: rtl/seg_chk_pkg.sv
// Shared types for the segment access checker.
// Assumes a 2-bit access kind code; code 3 is treated as a read.
package seg_chk_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_READ2 = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/seg_limit_cmp.sv
// Computes the effective byte limit from the limit field and the granularity
// bit, then flags an offset that lies above it. Purely combinational.
// Assumes the page shift fills the low bits with ones when granularity is set.
module seg_limit_cmp #(
    parameter int ADDR_W  = 32,
    parameter int LIM_W   = 20,
    parameter int PAGE_SH = 12
) (
    input  logic [LIM_W-1:0]  lim_field,
    input  logic              gran,
    input  logic [ADDR_W-1:0] ofs,
    output logic              over
);
    localparam int EXT_W = LIM_W + PAGE_SH;
    localparam int CMP_W = (ADDR_W > EXT_W) ? ADDR_W : EXT_W;

    logic [CMP_W-1:0] eff_lim;
    logic [CMP_W-1:0] ofs_ext;

    // Form the effective limit in byte units and compare it with the offset.
    always_comb begin
        if (gran)
            eff_lim = CMP_W'({lim_field, {PAGE_SH{1'b1}}});
        else
            eff_lim = CMP_W'(lim_field);
        ofs_ext = CMP_W'(ofs);
        over    = (ofs_ext > eff_lim);
    end
endmodule

// File: rtl/seg_rights_chk.sv
// Applies the privilege and type rules for one access. Combinational.
// Assumes lower numeric level = more privilege; fetches are not checked for
// privilege; reads are legal on both segment types.
module seg_rights_chk
    import seg_chk_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  acc_kind_e        kind,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  dpl,
    input  logic             is_code,
    output logic             priv_bad,
    output logic             type_bad
);
    // Decide privilege and type faults from the access kind.
    always_comb begin
        priv_bad = 1'b0;
        type_bad = 1'b0;
        unique case (kind)
            ACC_FETCH: type_bad = ~is_code;
            ACC_WRITE: begin
                priv_bad = (cpl > dpl);
                type_bad = is_code;
            end
            default:   priv_bad = (cpl > dpl);
        endcase
    end
endmodule

// File: rtl/seg_access_top.sv
// Segment access checker: registers the linear address (base + offset) and
// the limit, privilege and type fault flags one cycle after a request.
// Assumes the descriptor fields are stable alongside req_valid.
module seg_access_top
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIM_W   = 20,
    parameter int PAGE_SH = 12,
    parameter int PL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [LIM_W-1:0]  seg_limit,
    input  logic              seg_gran,
    input  logic [PL_W-1:0]   seg_dpl,
    input  logic              seg_is_code,
    input  logic [ADDR_W-1:0] offset,
    input  logic [PL_W-1:0]   cur_pl,
    input  logic [1:0]        acc_kind,
    output logic              res_valid,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              lin_ok,
    output logic              flt_limit,
    output logic              flt_priv,
    output logic              flt_type
);
    logic              lim_over;
    logic              priv_bad;
    logic              type_bad;
    logic [ADDR_W-1:0] sum_addr;

    seg_limit_cmp #(
        .ADDR_W (ADDR_W),
        .LIM_W  (LIM_W),
        .PAGE_SH(PAGE_SH)
    ) u_lim (
        .lim_field(seg_limit),
        .gran     (seg_gran),
        .ofs      (offset),
        .over     (lim_over)
    );

    seg_rights_chk #(
        .PL_W(PL_W)
    ) u_rights (
        .kind    (acc_kind_e'(acc_kind)),
        .cpl     (cur_pl),
        .dpl     (seg_dpl),
        .is_code (seg_is_code),
        .priv_bad(priv_bad),
        .type_bad(type_bad)
    );

    // Add base and offset; the carry out is dropped (modulo wrap).
    always_comb sum_addr = seg_base + offset;

    // Register the result; flags only follow a presented request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            lin_addr  <= '0;
            lin_ok    <= 1'b0;
            flt_limit <= 1'b0;
            flt_priv  <= 1'b0;
            flt_type  <= 1'b0;
        end else begin
            res_valid <= req_valid;
            lin_addr  <= sum_addr;
            lin_ok    <= req_valid & ~(lim_over | priv_bad | type_bad);
            flt_limit <= req_valid & lim_over;
            flt_priv  <= req_valid & priv_bad;
            flt_type  <= req_valid & type_bad;
        end
    end
endmodule

// File: rtl/seg_access_sva.sv
// Assertion checker for seg_access_top, attached by bind below.
// Assumes default parameter widths of the top.
module seg_access_sva #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 20,
    parameter int PL_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] seg_base,
    input logic [LIM_W-1:0]  seg_limit,
    input logic              seg_gran,
    input logic [PL_W-1:0]   seg_dpl,
    input logic              seg_is_code,
    input logic [ADDR_W-1:0] offset,
    input logic [PL_W-1:0]   cur_pl,
    input logic [1:0]        acc_kind,
    input logic              res_valid,
    input logic [ADDR_W-1:0] lin_addr,
    input logic              lin_ok,
    input logic              flt_limit,
    input logic              flt_priv,
    input logic              flt_type
);
    p_addr_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> lin_addr == $past(seg_base + offset));

    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && !lin_ok && !flt_limit && !flt_priv && !flt_type);

    p_byte_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !seg_gran && (offset > ADDR_W'(seg_limit)) |=> flt_limit);

    p_fetch_no_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && acc_kind == 2'd0 |=> !flt_priv);

    p_write_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && acc_kind == 2'd2 && seg_is_code |=> flt_type);

    p_ok_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lin_ok |-> res_valid && !flt_limit && !flt_priv && !flt_type);

    p_priv_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && acc_kind != 2'd0 && cur_pl > seg_dpl |=> flt_priv);
endmodule

bind seg_access_top seg_access_sva #(
    .ADDR_W(ADDR_W),
    .LIM_W (LIM_W),
    .PL_W  (PL_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .seg_base   (seg_base),
    .seg_limit  (seg_limit),
    .seg_gran   (seg_gran),
    .seg_dpl    (seg_dpl),
    .seg_is_code(seg_is_code),
    .offset     (offset),
    .cur_pl     (cur_pl),
    .acc_kind   (acc_kind),
    .res_valid  (res_valid),
    .lin_addr   (lin_addr),
    .lin_ok     (lin_ok),
    .flt_limit  (flt_limit),
    .flt_priv   (flt_priv),
    .flt_type   (flt_type)
);

// File: tb/seg_access_top_tb_top.sv
// Sweep bench for seg_access_top: privilege x kind x type x granularity x
// limit boundary, with expected results worked out arithmetically.
module seg_access_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] seg_base = '0;
    logic [19:0] seg_limit = '0;
    logic        seg_gran = 1'b0;
    logic [1:0]  seg_dpl = '0;
    logic        seg_is_code = 1'b0;
    logic [31:0] offset = '0;
    logic [1:0]  cur_pl = '0;
    logic [1:0]  acc_kind = '0;
    logic        res_valid, lin_ok, flt_limit, flt_priv, flt_type;
    logic [31:0] lin_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    seg_access_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_gran(seg_gran),
        .seg_dpl(seg_dpl), .seg_is_code(seg_is_code), .offset(offset),
        .cur_pl(cur_pl), .acc_kind(acc_kind), .res_valid(res_valid),
        .lin_addr(lin_addr), .lin_ok(lin_ok), .flt_limit(flt_limit),
        .flt_priv(flt_priv), .flt_type(flt_type)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request, checked one cycle later against arithmetic expectations.
    task automatic one_req(input logic [31:0] b, input logic [19:0] lim, input logic g,
                           input logic [1:0] dpl, input logic code, input logic [31:0] ofs,
                           input logic [1:0] cpl, input logic [1:0] kind);
        logic [63:0] eff;
        logic e_lim, e_priv, e_type;
        @(negedge clk);
        req_valid = 1'b1; seg_base = b; seg_limit = lim; seg_gran = g;
        seg_dpl = dpl; seg_is_code = code; offset = ofs; cur_pl = cpl; acc_kind = kind;
        eff    = g ? ((64'(lim) << 12) | 64'hFFF) : 64'(lim);
        e_lim  = 64'(ofs) > eff;
        // R9: kind 3 behaves as a read (1); 0 fetch, 2 write
        e_priv = (kind != 2'd0) && (cpl > dpl);
        e_type = (kind == 2'd0 && !code) || (kind == 2'd2 && code);
        @(negedge clk);
        chk("R1 lin_addr", lin_addr, b + ofs);
        chk("R2 res_valid", 32'(res_valid), 32'd1);
        chk(g ? "R4 flt_limit" : "R3 flt_limit", 32'(flt_limit), 32'(e_lim));
        chk(kind == 2'd0 ? "R6 flt_priv" : "R5 flt_priv", 32'(flt_priv), 32'(e_priv));
        chk("R7 flt_type", 32'(flt_type), 32'(e_type));
        chk("R8 lin_ok", 32'(lin_ok), 32'(!(e_lim || e_priv || e_type)));
        req_valid = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] lims [3];
        logic [31:0] base_v;
        lims[0] = 20'h0; lims[1] = 20'h00005; lims[2] = 20'hFFFFF;
        base_v = 32'hFFFF_F800;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 reset res_valid", 32'(res_valid), 32'd0);
        chk("R2 reset lin_ok", 32'(lin_ok), 32'd0);
        chk("R2 reset faults", 32'({flt_limit, flt_priv, flt_type}), 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            for (int k = 0; k < 4; k++)
              for (int t = 0; t < 2; t++)
                for (int g = 0; g < 2; g++)
                  for (int li = 0; li < 3; li++)
                    for (int dlt = -1; dlt <= 1; dlt++) begin
                        logic [31:0] effl;
                        effl = (g != 0) ? {lims[li], 12'hFFF} : 32'(lims[li]);
                        base_v = base_v + 32'h0001_3579;
                        one_req(base_v, lims[li], g[0], d[1:0], t[0],
                                effl + 32'(dlt), c[1:0], k[1:0]);
                    end
        // R2: idle cycle after a request leaves everything low
        @(negedge clk);
        chk("R2 idle res_valid", 32'(res_valid), 32'd0);
        chk("R2 idle flags", 32'({lin_ok, flt_limit, flt_priv, flt_type}), 32'd0);
        // R2: a faulting request then reset clears outputs
        one_req(32'h0, 20'h0, 1'b0, 2'd0, 1'b1, 32'h10, 2'd3, 2'd2);
        req_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 reset clears faults", 32'({res_valid, lin_ok, flt_limit, flt_priv, flt_type}), 32'd0);
        req_valid = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule